// File: doc/BRIEF.md
# Critical-Word-First Line Refill Engine

This block fills one data-cache line after a load miss. It reads the line from a pipelined bus, one 64-bit doubleword per beat. The burst does not start at the beginning of the line. It starts at the doubleword the missing load asked for, then walks forward and wraps around inside the line. The missing load is completed on the beat that carries its own doubleword, and the rest of the line keeps streaming in behind it.

The engine is started by a miss request carrying the line index, the tag, the starting row and the victim way. It drives the bus cycle, strobe and doubleword address, and writes each returned beat into the data RAM of the victim way. One cycle after the refill begins it writes the new tag. It keeps a valid bit for every row of the line in flight. A probe port lets later accesses ask whether they can be served from the line being filled: a load needs its row to be present, while a store to that line always counts as a hit. When the last beat arrives, the bus cycle closes and the line is marked valid for the chosen way.

Top module: `cwf_refill`

## Requirements
- R1: A miss request seen while idle raises `bus_cyc` and `bus_stb` on the next cycle. The first bus address is `{tag, index, start row}`, and the row sits in the low 3 bits.
- R2: The address moves only after an accepted beat (`bus_stb` high and `bus_stall` low). It then moves one row up, wrapping modulo 8 in the low 3 bits, and the tag and index bits stay as they were. While `bus_stall` is high with `bus_stb`, the address and strobe hold.
- R3: Exactly 8 addresses are issued per refill. `bus_stb` drops after the address whose row is (start row − 1) mod 8 has been accepted.
- R4: Each ack writes `bus_dat` into the data RAM in the same cycle. Only the victim way's bit of `ram_we` is set, `ram_row` is `{index, acked row}`, and all 8 bits of `ram_sel` are 1.
- R5: `rows_valid` reads all zero on the first cycle of a refill. Bit r (row r of the line) becomes 1 on the cycle after row r's ack.
- R6: `miss_done` pulses in the same cycle as the ack of the starting row, and `miss_data` equals that beat's data. No other ack raises it.
- R7: `tag_we` is high for exactly one cycle, the second cycle of the refill, and carries the request's index, way and tag.
- R8: The eighth ack raises `line_valid_set` in the same cycle, with the request's index and way. On the next cycle `bus_cyc` and `busy` are low.
- R9: A load probe (`probe_load`=1) hits only while a refill is running, its index and tag match the line, and its row's valid bit is set. `probe_way` then gives the victim way.
- R10: A store probe (`probe_load`=0) with matching index and tag hits for the whole refill, whatever the row valid bits are.
- R11: A miss request that arrives while `busy` is high is ignored. It issues no address and does not change the refill in progress.
- R12: After reset the engine is idle: `busy`, `bus_cyc`, `bus_stb`, `tag_we`, `line_valid_set` and `ram_we` are low, and `rows_valid` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Load-miss request strobe |
| miss_index | input | IDX_W | Line index of the miss |
| miss_tag | input | TAG_W | Tag of the missing line |
| miss_row | input | 3 | Doubleword row the load needs |
| miss_way | input | WAY_W | Victim way to fill |
| busy | output | 1 | A refill is in progress |
| bus_cyc | output | 1 | Bus cycle active |
| bus_stb | output | 1 | Bus read strobe |
| bus_adr | output | TAG_W+IDX_W+3 | Doubleword address |
| bus_stall | input | 1 | Bus cannot take the strobe |
| bus_ack | input | 1 | Read data beat valid |
| bus_dat | input | 64 | Read data |
| ram_we | output | WAYS | Per-way data RAM write enable |
| ram_row | output | IDX_W+3 | Data RAM row address |
| ram_sel | output | 8 | Byte-lane enables |
| ram_data | output | 64 | Data RAM write data |
| tag_we | output | 1 | Tag RAM write strobe |
| tag_index | output | IDX_W | Tag RAM index |
| tag_way | output | WAY_W | Tag RAM way |
| tag_value | output | TAG_W | New tag |
| line_valid_set | output | 1 | Mark line valid |
| line_valid_index | output | IDX_W | Index to mark |
| line_valid_way | output | WAY_W | Way to mark |
| rows_valid | output | 8 | Per-row valid bits of the filling line |
| miss_done | output | 1 | Missing load completes |
| miss_data | output | 64 | Data for the missing load |
| probe_valid | input | 1 | Probe request present |
| probe_load | input | 1 | 1 = load probe, 0 = store probe |
| probe_index | input | IDX_W | Probe line index |
| probe_tag | input | TAG_W | Probe tag |
| probe_row | input | 3 | Probe row |
| probe_hit | output | 1 | Probe served by the filling line |
| probe_way | output | WAY_W | Way holding the filling line |

## Verification
Refills are started at rows 0, 3, 5 and 7. Row 0 gives a burst that never wraps. Row 7 puts the wrap on the first step, and rows 3 and 5 wrap in the middle, so a wrong final-row calculation shows up as a short or long burst. The bus is run with no stall, with sparse stalls and with heavy stalls, and with ack latencies of one to three cycles. These separate stepping the address on a held beat from stepping it on an accepted one, and they move the start-row ack away from the strobe that requested it. Load and store probes cycle through every row on every cycle, with a wrong tag mixed in, so that the per-row valid gating of loads can be told apart from the unconditional hit of stores. Extra miss requests are injected mid-refill to show they are dropped.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

    localparam int ROWS_PER_LINE = 8;
    localparam int ROW_W         = $clog2(ROWS_PER_LINE);
    localparam int DATA_W        = 64;
    localparam int LANES         = DATA_W / 8;

    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [DATA_W-1:0] dword_t;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } fill_state_e;

    // Next row inside the line, wrapping at the line boundary.
    function automatic row_t row_step(row_t r);
        return row_t'(r + 1'b1);
    endfunction

    // Final row of a burst that starts at s.
    function automatic row_t row_final(row_t s);
        return row_t'(s - 1'b1);
    endfunction

endpackage

// File: rtl/cwf_issue.sv
module cwf_issue
    import cwf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [ROW_W-1:0] start_row,
    input  logic             stall,
    output logic             stb,
    output logic [ROW_W-1:0] row
);

    row_t last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb    <= 1'b0;
            row    <= '0;
            last_q <= '0;
        end else if (start) begin
            stb    <= 1'b1;
            row    <= start_row;
            last_q <= row_final(start_row);
        end else if (stb && !stall) begin
            if (row == last_q) begin
                stb <= 1'b0;
            end else begin
                row <= row_step(row);
            end
        end
    end

endmodule

// File: rtl/cwf_track.sv
module cwf_track
    import cwf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [ROW_W-1:0]         start_row,
    input  logic                     ack,
    output logic [ROWS_PER_LINE-1:0] rows_valid,
    output logic [ROW_W-1:0]         ack_row,
    output logic                     first_ack,
    output logic                     final_ack
);

    row_t start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_row <= '0;
            start_q <= '0;
        end else if (start) begin
            ack_row <= start_row;
            start_q <= start_row;
        end else if (ack) begin
            ack_row <= row_step(ack_row);
        end
    end

    for (genvar r = 0; r < ROWS_PER_LINE; r++) begin : g_row_valid
        always_ff @(posedge clk) begin
            if (rst || start) begin
                rows_valid[r] <= 1'b0;
            end else if (ack && (ack_row == ROW_W'(r))) begin
                rows_valid[r] <= 1'b1;
            end
        end
    end

    assign first_ack = ack && (ack_row == start_q);
    assign final_ack = ack && (ack_row == row_final(start_q));

endmodule

// File: rtl/cwf_probe.sv
module cwf_probe
    import cwf_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 20
) (
    input  logic                     filling,
    input  logic [IDX_W-1:0]         line_index,
    input  logic [TAG_W-1:0]         line_tag,
    input  logic [ROWS_PER_LINE-1:0] rows_valid,
    input  logic                     probe_valid,
    input  logic                     probe_load,
    input  logic [IDX_W-1:0]         probe_index,
    input  logic [TAG_W-1:0]         probe_tag,
    input  logic [ROW_W-1:0]         probe_row,
    output logic                     probe_hit
);

    logic same_line;
    logic row_ready;

    always_comb begin
        same_line = filling && probe_valid &&
                    (probe_index == line_index) && (probe_tag == line_tag);
        // Stores may merge before the row lands; loads wait for it.
        row_ready = !probe_load || rows_valid[probe_row];
        probe_hit = same_line && row_ready;
    end

endmodule

// File: rtl/cwf_refill.sv
module cwf_refill
    import cwf_pkg::*;
#(
    parameter  int IDX_W = 4,
    parameter  int TAG_W = 20,
    parameter  int WAYS  = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int ADR_W = TAG_W + IDX_W + ROW_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     miss_valid,
    input  logic [IDX_W-1:0]         miss_index,
    input  logic [TAG_W-1:0]         miss_tag,
    input  logic [ROW_W-1:0]         miss_row,
    input  logic [WAY_W-1:0]         miss_way,
    output logic                     busy,
    output logic                     bus_cyc,
    output logic                     bus_stb,
    output logic [ADR_W-1:0]         bus_adr,
    input  logic                     bus_stall,
    input  logic                     bus_ack,
    input  logic [DATA_W-1:0]        bus_dat,
    output logic [WAYS-1:0]          ram_we,
    output logic [IDX_W+ROW_W-1:0]   ram_row,
    output logic [LANES-1:0]         ram_sel,
    output logic [DATA_W-1:0]        ram_data,
    output logic                     tag_we,
    output logic [IDX_W-1:0]         tag_index,
    output logic [WAY_W-1:0]         tag_way,
    output logic [TAG_W-1:0]         tag_value,
    output logic                     line_valid_set,
    output logic [IDX_W-1:0]         line_valid_index,
    output logic [WAY_W-1:0]         line_valid_way,
    output logic [ROWS_PER_LINE-1:0] rows_valid,
    output logic                     miss_done,
    output logic [DATA_W-1:0]        miss_data,
    input  logic                     probe_valid,
    input  logic                     probe_load,
    input  logic [IDX_W-1:0]         probe_index,
    input  logic [TAG_W-1:0]         probe_tag,
    input  logic [ROW_W-1:0]         probe_row,
    output logic                     probe_hit,
    output logic [WAY_W-1:0]         probe_way
);

    fill_state_e      state_q;
    logic [IDX_W-1:0] idx_q;
    logic [TAG_W-1:0] tag_q;
    logic [WAY_W-1:0] way_q;
    logic             tag_arm_q;
    logic             tag_we_q;

    logic accept;
    logic filling;
    logic ack_in;
    row_t issue_row;
    row_t ack_row;
    logic first_ack;
    logic final_ack;
    logic issue_stb;

    assign filling = (state_q == FILL_BUSY);
    assign accept  = miss_valid && (state_q == FILL_IDLE);
    assign ack_in  = bus_ack && filling;

    // Control state and captured request
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= FILL_IDLE;
            idx_q     <= '0;
            tag_q     <= '0;
            way_q     <= '0;
            tag_arm_q <= 1'b0;
            tag_we_q  <= 1'b0;
        end else begin
            tag_we_q  <= tag_arm_q;
            tag_arm_q <= 1'b0;
            if (accept) begin
                state_q   <= FILL_BUSY;
                idx_q     <= miss_index;
                tag_q     <= miss_tag;
                way_q     <= miss_way;
                tag_arm_q <= 1'b1;
            end else if (final_ack) begin
                state_q <= FILL_IDLE;
            end
        end
    end

    cwf_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .start_row (miss_row),
        .stall     (bus_stall),
        .stb       (issue_stb),
        .row       (issue_row)
    );

    cwf_track u_track (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .start_row  (miss_row),
        .ack        (ack_in),
        .rows_valid (rows_valid),
        .ack_row    (ack_row),
        .first_ack  (first_ack),
        .final_ack  (final_ack)
    );

    cwf_probe #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_probe (
        .filling     (filling),
        .line_index  (idx_q),
        .line_tag    (tag_q),
        .rows_valid  (rows_valid),
        .probe_valid (probe_valid),
        .probe_load  (probe_load),
        .probe_index (probe_index),
        .probe_tag   (probe_tag),
        .probe_row   (probe_row),
        .probe_hit   (probe_hit)
    );

    // Bus side
    assign busy    = filling;
    assign bus_cyc = filling;
    assign bus_stb = issue_stb;
    assign bus_adr = {tag_q, idx_q, issue_row};

    // Data RAM write port: one enable per way
    for (genvar w = 0; w < WAYS; w++) begin : g_way_we
        assign ram_we[w] = ack_in && (way_q == WAY_W'(w));
    end
    assign ram_row  = {idx_q, ack_row};
    assign ram_sel  = '1;
    assign ram_data = bus_dat;

    // Tag write, one cycle after the refill starts
    assign tag_we    = tag_we_q;
    assign tag_index = idx_q;
    assign tag_way   = way_q;
    assign tag_value = tag_q;

    // Completion
    assign line_valid_set   = final_ack;
    assign line_valid_index = idx_q;
    assign line_valid_way   = way_q;
    assign miss_done        = first_ack;
    assign miss_data        = bus_dat;
    assign probe_way        = way_q;

endmodule

// File: rtl/cwf_refill_chk.sv
module cwf_refill_chk
    import cwf_pkg::*;
#(
    parameter  int IDX_W = 4,
    parameter  int TAG_W = 20,
    parameter  int WAYS  = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int ADR_W = TAG_W + IDX_W + ROW_W
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     miss_valid,
    input logic [IDX_W-1:0]         miss_index,
    input logic [TAG_W-1:0]         miss_tag,
    input logic [ROW_W-1:0]         miss_row,
    input logic                     busy,
    input logic                     bus_cyc,
    input logic                     bus_stb,
    input logic [ADR_W-1:0]         bus_adr,
    input logic                     bus_stall,
    input logic                     bus_ack,
    input logic [WAYS-1:0]          ram_we,
    input logic [LANES-1:0]         ram_sel,
    input logic                     tag_we,
    input logic                     line_valid_set,
    input logic [ROWS_PER_LINE-1:0] rows_valid,
    input logic                     miss_done
);

    logic start_seen;
    assign start_seen = miss_valid && !busy;

    a_r1_first_addr: assert property (@(posedge clk) disable iff (rst)
        start_seen |=> bus_cyc && bus_stb &&
                       bus_adr == {$past(miss_tag), $past(miss_index), $past(miss_row)});

    a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        bus_stb && bus_stall |=> bus_stb && $stable(bus_adr));

    a_r2_row_step: assert property (@(posedge clk) disable iff (rst)
        bus_stb && !bus_stall |=> !bus_stb ||
            (bus_adr[ROW_W-1:0] == ROW_W'($past(bus_adr[ROW_W-1:0]) + 1'b1) &&
             bus_adr[ADR_W-1:ROW_W] == $past(bus_adr[ADR_W-1:ROW_W])));

    a_r3_stb_in_cycle: assert property (@(posedge clk) disable iff (rst)
        bus_stb |-> bus_cyc);

    a_r4_one_way: assert property (@(posedge clk) disable iff (rst)
        $countones(ram_we) <= 1);

    a_r4_full_lanes: assert property (@(posedge clk) disable iff (rst)
        (ram_we != '0) |-> bus_ack && (ram_sel == '1));

    a_r5_rows_clear: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_cyc) |-> rows_valid == '0);

    a_r6_done_with_ack: assert property (@(posedge clk) disable iff (rst)
        miss_done |-> bus_ack && (ram_we != '0));

    a_r7_tag_slot: assert property (@(posedge clk) disable iff (rst)
        start_seen |=> !tag_we ##1 tag_we);

    a_r8_cycle_ends: assert property (@(posedge clk) disable iff (rst)
        line_valid_set |=> !bus_cyc && !bus_stb);

endmodule

bind cwf_refill cwf_refill_chk #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .WAYS  (WAYS)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .miss_valid     (miss_valid),
    .miss_index     (miss_index),
    .miss_tag       (miss_tag),
    .miss_row       (miss_row),
    .busy           (busy),
    .bus_cyc        (bus_cyc),
    .bus_stb        (bus_stb),
    .bus_adr        (bus_adr),
    .bus_stall      (bus_stall),
    .bus_ack        (bus_ack),
    .ram_we         (ram_we),
    .ram_sel        (ram_sel),
    .tag_we         (tag_we),
    .line_valid_set (line_valid_set),
    .rows_valid     (rows_valid),
    .miss_done      (miss_done)
);

// File: tb/tb_cwf_refill.sv
module tb_cwf_refill;

    localparam int IDX_W = 4;
    localparam int TAG_W = 20;
    localparam int WAYS  = 2;
    localparam int WAY_W = 1;
    localparam int ADR_W = TAG_W + IDX_W + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic             miss_valid = 1'b0;
    logic [IDX_W-1:0] miss_index = '0;
    logic [TAG_W-1:0] miss_tag = '0;
    logic [2:0]       miss_row = '0;
    logic [WAY_W-1:0] miss_way = '0;
    logic             busy, bus_cyc, bus_stb;
    logic [ADR_W-1:0] bus_adr;
    logic             bus_stall = 1'b0, bus_ack = 1'b0;
    logic [63:0]      bus_dat = '0;
    logic [WAYS-1:0]  ram_we;
    logic [IDX_W+2:0] ram_row;
    logic [7:0]       ram_sel;
    logic [63:0]      ram_data;
    logic             tag_we;
    logic [IDX_W-1:0] tag_index;
    logic [WAY_W-1:0] tag_way;
    logic [TAG_W-1:0] tag_value;
    logic             line_valid_set;
    logic [IDX_W-1:0] line_valid_index;
    logic [WAY_W-1:0] line_valid_way;
    logic [7:0]       rows_valid;
    logic             miss_done;
    logic [63:0]      miss_data;
    logic             probe_valid = 1'b0, probe_load = 1'b0;
    logic [IDX_W-1:0] probe_index = '0;
    logic [TAG_W-1:0] probe_tag = '0;
    logic [2:0]       probe_row = '0;
    logic             probe_hit;
    logic [WAY_W-1:0] probe_way;

    cwf_refill #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WAYS(WAYS)) dut (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_index(miss_index), .miss_tag(miss_tag),
        .miss_row(miss_row), .miss_way(miss_way), .busy(busy),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_adr(bus_adr),
        .bus_stall(bus_stall), .bus_ack(bus_ack), .bus_dat(bus_dat),
        .ram_we(ram_we), .ram_row(ram_row), .ram_sel(ram_sel), .ram_data(ram_data),
        .tag_we(tag_we), .tag_index(tag_index), .tag_way(tag_way), .tag_value(tag_value),
        .line_valid_set(line_valid_set), .line_valid_index(line_valid_index),
        .line_valid_way(line_valid_way), .rows_valid(rows_valid),
        .miss_done(miss_done), .miss_data(miss_data),
        .probe_valid(probe_valid), .probe_load(probe_load), .probe_index(probe_index),
        .probe_tag(probe_tag), .probe_row(probe_row),
        .probe_hit(probe_hit), .probe_way(probe_way)
    );

    int n_chk  = 0;
    int n_fail = 0;
    logic finished = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] memval(input logic [ADR_W-1:0] a);
        return (64'(a) << 20) ^ 64'(a) ^ 64'hC3A5_0F1E_7788_9911;
    endfunction

    // Scoreboard state
    logic [ADR_W-1:0] exp_adr[$];
    logic [ADR_W-1:0] pend_adr[$];
    int               pend_t[$];

    logic [IDX_W-1:0] cur_idx = '0;
    logic [TAG_W-1:0] cur_tag = '0;
    logic [2:0]       cur_row = '0;
    logic [WAY_W-1:0] cur_way = '0;
    int  stall_mode = 0;
    int  lat = 1;
    int  fills_done = 0;

    int  cyc_n = 0;
    logic filling_m = 1'b0;
    logic [7:0] vmodel = '0;
    int  acks_seen = 0;
    int  tcnt = 10;
    logic first_pop = 1'b0;
    logic prev_hold = 1'b0;
    logic [ADR_W-1:0] prev_adr = '0;
    logic ack_now;
    logic [ADR_W-1:0] ack_a;
    logic [ADR_W-1:0] e_a;
    logic exp_hit;

    // Bus slave model and monitor
    always @(negedge clk) begin
        if (!rst) begin
            cyc_n++;
            ack_now = (pend_adr.size() > 0) && (pend_t[0] <= cyc_n);
            if (ack_now) begin
                ack_a = pend_adr.pop_front();
                void'(pend_t.pop_front());
                bus_ack = 1'b1;
                bus_dat = memval(ack_a);
            end else begin
                bus_ack = 1'b0;
                bus_dat = 64'hDEAD_BEEF_0BAD_F00D;
            end
            case (stall_mode)
                1:       bus_stall = (cyc_n % 3 == 1);
                2:       bus_stall = (cyc_n % 4 != 0);
                default: bus_stall = 1'b0;
            endcase
            probe_valid = 1'b1;
            probe_load  = ((cyc_n / 8) % 2) == 0;
            probe_row   = 3'(cyc_n % 8);
            probe_index = cur_idx;
            probe_tag   = (cyc_n % 5 == 0) ? (cur_tag ^ 20'h1) : cur_tag;
            #1;

            chk("R1/R8 bus_cyc tracks refill", 64'(bus_cyc), 64'(filling_m));
            if (filling_m) chk("R5 rows_valid", 64'(rows_valid), 64'(vmodel));

            exp_hit = filling_m && probe_valid && (probe_tag == cur_tag) &&
                      (probe_index == cur_idx) && (!probe_load || vmodel[probe_row]);
            if (probe_load) chk("R9 load probe hit", 64'(probe_hit), 64'(exp_hit));
            else            chk("R10 store probe hit", 64'(probe_hit), 64'(exp_hit));
            if (exp_hit) chk("R9 probe way", 64'(probe_way), 64'(cur_way));

            if (tcnt < 10) tcnt++;
            if (tcnt >= 1 && tcnt <= 3) chk("R7 tag write slot", 64'(tag_we), 64'(tcnt == 2));
            if (tcnt == 2) chk("R7 tag fields", {32'(tag_value), 16'(tag_index), 16'(tag_way)},
                               {32'(cur_tag), 16'(cur_idx), 16'(cur_way)});

            if (prev_hold) chk("R2 hold under stall", {63'(bus_adr), bus_stb}, {63'(prev_adr), 1'b1});

            if (ack_now) begin
                chk("R4 way enable", 64'(ram_we), 64'(1) << cur_way);
                chk("R4 ram row", 64'(ram_row), 64'({cur_idx, ack_a[2:0]}));
                chk("R4 ram data", ram_data, memval(ack_a));
                chk("R4 byte lanes", 64'(ram_sel), 64'hFF);
                chk("R6 miss_done on start row", 64'(miss_done), 64'(ack_a[2:0] == cur_row));
                if (ack_a[2:0] == cur_row) chk("R6 miss_data", miss_data, memval(ack_a));
                acks_seen++;
                chk("R8 line_valid_set on last ack", 64'(line_valid_set), 64'(acks_seen == 8));
                if (acks_seen == 8) begin
                    chk("R8 line index/way", {32'(line_valid_index), 32'(line_valid_way)},
                        {32'(cur_idx), 32'(cur_way)});
                    filling_m = 1'b0;
                    fills_done++;
                end
                vmodel[ack_a[2:0]] = 1'b1;
            end else begin
                chk("R4 no write without ack", 64'(ram_we), 64'(0));
                chk("R6 no miss_done without ack", 64'(miss_done), 64'(0));
                chk("R8 no line_valid_set", 64'(line_valid_set), 64'(0));
            end

            prev_hold = bus_stb && bus_stall;
            prev_adr  = bus_adr;
            if (bus_stb && !bus_stall) begin
                if (exp_adr.size() == 0) begin
                    chk("R3 strobe beyond eight beats", 64'(bus_stb), 64'(0));
                end else begin
                    e_a = exp_adr.pop_front();
                    if (first_pop) chk("R1 first address", 64'(bus_adr), 64'(e_a));
                    else           chk("R2 address order", 64'(bus_adr), 64'(e_a));
                    first_pop = 1'b0;
                    pend_adr.push_back(bus_adr);
                    pend_t.push_back(cyc_n + lat);
                end
            end

            if (miss_valid && !filling_m) begin
                filling_m = 1'b1;
                vmodel    = '0;
                acks_seen = 0;
                tcnt      = 0;
                first_pop = 1'b1;
            end
        end
    end

    // Driver: pushes the expected address sequence, then issues the miss
    task automatic run_fill(input logic [IDX_W-1:0] idx, input logic [TAG_W-1:0] tg,
                            input logic [2:0] row, input logic [WAY_W-1:0] way,
                            input int smode, input int l, input logic extra);
        int start_cnt;
        @(negedge clk);
        cur_idx = idx; cur_tag = tg; cur_row = row; cur_way = way;
        stall_mode = smode; lat = l;
        for (int k = 0; k < 8; k++) exp_adr.push_back({tg, idx, 3'(row + 3'(k))});
        start_cnt  = fills_done;
        miss_valid = 1'b1; miss_index = idx; miss_tag = tg; miss_row = row; miss_way = way;
        @(negedge clk);
        miss_valid = 1'b0;
        if (extra) begin
            repeat (3) @(negedge clk);
            // R11: request while busy must be dropped
            miss_valid = 1'b1; miss_row = 3'(row + 3'd3); miss_index = idx ^ 4'h1;
            miss_way = ~way;
            @(negedge clk);
            miss_valid = 1'b0;
        end
        while (fills_done == start_cnt) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R11 idle after refill, nothing extra", {62'(exp_adr.size()), busy, bus_stb}, 64'(0));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R12 reset outputs", {57'(0), busy, bus_cyc, bus_stb, tag_we, line_valid_set, ram_we},
            64'(0));
        chk("R12 reset rows_valid", 64'(rows_valid), 64'(0));
        run_fill(4'd3,  20'h12345, 3'd0, 1'b0, 0, 1, 1'b0);
        run_fill(4'd9,  20'hABCDE, 3'd5, 1'b1, 1, 2, 1'b1);
        run_fill(4'd15, 20'h00F0F, 3'd7, 1'b0, 2, 3, 1'b0);
        run_fill(4'd0,  20'hFFFFF, 3'd3, 1'b1, 2, 1, 1'b1);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule